// File: doc/BRIEF.md
# Register-result integer ALU

This block is the combinational execute unit of a simple load/store processor that has no condition flags. It takes two operands of `DATA_W` bits and a 4-bit function code, and returns one result word. The second operand may be a register value or an immediate that the decode stage has already sign-extended to the full width. The ALU treats both cases the same way, so a small negative immediate reaches the bitwise operations as a full-width pattern.

Comparisons do not set flags. Each comparison writes 1 or 0 into the result word, and a later conditional branch tests that word against zero. The function set covers:

- two's-complement add, subtract and multiply (low half of the product);
- signed division that truncates toward zero, with defined results for a zero divisor and for overflow;
- bitwise and, or and xor;
- six signed comparisons;
- a left shift and a logical right shift.

Top module: `int_alu_core`

## Requirements
- R1: The function code selects the operation as follows: 0 add, 1 sub, 2 mul, 3 div, 4 and, 5 or, 6 xor, 7 eq, 8 ne, 9 lt, 10 le, 11 gt, 12 ge, 13 shl, 14 shr. The result follows the operands and code combinationally, so all-zero inputs give a zero result.
- R2: add returns op_a + op_b and sub returns op_a - op_b, both modulo 2^DATA_W.
- R3: mul returns the low DATA_W bits of the product of op_a and op_b.
- R4: div treats both operands as signed and returns the quotient truncated toward zero (7 / -2 = -3, -7 / 2 = -3, -7 / -2 = 3).
- R5: div with op_b equal to zero returns all ones and raises no other signal.
- R6: div of the most negative value by -1 returns the most negative value.
- R7: and, or and xor work bit by bit. xor with an all-ones op_b returns the complement of op_a.
- R8: eq, ne, lt, le, gt and ge compare op_a and op_b as signed two's-complement values. The result is exactly 1 when the relation holds and exactly 0 when it does not.
- R9: shl shifts op_a left by the value in the low log2(DATA_W) bits of op_b, fills with zeros, and ignores all higher bits of op_b. A shift value of 32 therefore leaves op_a unchanged.
- R10: shr is a logical right shift by the same low bits of op_b and fills the vacated upper bits with zeros, even when op_a is negative.
- R11: Function code 15 is unused and returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_W (32) | First operand, always a register value |
| op_b | input | DATA_W (32) | Second operand: a register value or an already sign-extended immediate |
| func | input | 4 | Function code (see R1) |
| result | output | DATA_W (32) | Result word; comparisons give 0 or 1 |

## Verification
The bench builds the block with DATA_W = 32 and SHIFT_STAGED = 1. This selects the staged shifter that reverses the word for right shifts, so every shift check exercises the reversal and stage chain rather than a plain operator. At 32 bits the bench can use exact corner words: the most negative value, the largest positive value, -1, and shift values whose bits sit above the five that count. Against these words it checks sign-crossing comparisons, all four sign cases of truncating division, the zero-divisor rule and the overflowing quotient. It also runs every function code over several operand pairs and compares each result with a model written in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      FN_ADD = 4'd0,
      FN_SUB = 4'd1,
      FN_MUL = 4'd2,
      FN_DIV = 4'd3,
      FN_AND = 4'd4,
      FN_OR  = 4'd5,
      FN_XOR = 4'd6,
      FN_EQ  = 4'd7,
      FN_NE  = 4'd8,
      FN_LT  = 4'd9,
      FN_LE  = 4'd10,
      FN_GT  = 4'd11,
      FN_GE  = 4'd12,
      FN_SHL = 4'd13,
      FN_SHR = 4'd14,
      FN_RSV = 4'd15
   } alu_fn_e;

   typedef struct packed {
      logic eq;
      logic ne;
      logic lt;
      logic le;
      logic gt;
      logic ge;
   } rel_flags_t;

endpackage

// File: rtl/int_alu_arith.sv
module int_alu_arith #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W-1:0] diff,
   output logic [DATA_W-1:0] prod,
   output logic [DATA_W-1:0] quot
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] mag_a;
   logic [DATA_W-1:0] mag_b;
   logic [DATA_W-1:0] mag_q;
   logic              neg_q;
   logic              b_zero;

   assign sum  = a + b;
   assign diff = a - b;
   assign prod = a * b;

   // The quotient is formed from magnitudes. Negating the most negative
   // value gives itself, read as an unsigned magnitude of 2^(DATA_W-1), so
   // the overflowing case falls out without a special path.
   always_comb begin
      mag_a  = a[MSB] ? -a : a;
      mag_b  = b[MSB] ? -b : b;
      neg_q  = a[MSB] ^ b[MSB];
      b_zero = (b == '0);
      mag_q  = b_zero ? '0 : (mag_a / mag_b);
      if (b_zero)
         quot = '1;
      else if (neg_q)
         quot = -mag_q;
      else
         quot = mag_q;
   end

endmodule

// File: rtl/int_alu_compare.sv
module int_alu_compare
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output rel_flags_t        rel
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] gap;
   logic              signs_differ;
   logic              less;
   logic              same;

   // Signed less-than from one subtractor. When the signs differ, the
   // negative operand is the smaller one. Otherwise the difference cannot
   // overflow and its sign bit decides.
   always_comb begin
      gap          = a - b;
      signs_differ = a[MSB] ^ b[MSB];
      less         = signs_differ ? a[MSB] : gap[MSB];
      same         = (a == b);
      rel.eq       = same;
      rel.ne       = ~same;
      rel.lt       = less;
      rel.le       = less | same;
      rel.gt       = ~(less | same);
      rel.ge       = ~less;
   end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
   parameter int DATA_W       = 32,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [DATA_W-1:0]         data,
   input  logic [$clog2(DATA_W)-1:0] amt,
   input  logic                      go_right,
   output logic [DATA_W-1:0]         shifted
);
   localparam int AMT_W = $clog2(DATA_W);

   generate
      if (SHIFT_STAGED) begin : g_staged
         // One left-shifting chain serves both directions. A right shift
         // reverses the word on the way in and on the way out.
         logic [DATA_W-1:0] chain [AMT_W+1];
         logic [DATA_W-1:0] flipped_in;
         logic [DATA_W-1:0] flipped_out;

         always_comb begin
            for (int i = 0; i < DATA_W; i++)
               flipped_in[i] = data[DATA_W-1-i];
         end

         assign chain[0] = go_right ? flipped_in : data;

         for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            assign chain[s+1] = amt[s] ? (chain[s] << (1 << s)) : chain[s];
         end

         always_comb begin
            for (int i = 0; i < DATA_W; i++)
               flipped_out[i] = chain[AMT_W][DATA_W-1-i];
         end

         assign shifted = go_right ? flipped_out : chain[AMT_W];
      end else begin : g_operator
         assign shifted = go_right ? (data >> amt) : (data << amt);
      end
   endgenerate

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [3:0]        func,
   output logic [DATA_W-1:0] result
);
   localparam int AMT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("int_alu_core: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] sum_w;
   logic [DATA_W-1:0] diff_w;
   logic [DATA_W-1:0] prod_w;
   logic [DATA_W-1:0] quot_w;
   logic [DATA_W-1:0] shift_w;
   rel_flags_t        rel_w;
   alu_fn_e           fn;

   assign fn = alu_fn_e'(func);

   int_alu_arith #(.DATA_W(DATA_W)) u_arith (
      .a    (op_a),
      .b    (op_b),
      .sum  (sum_w),
      .diff (diff_w),
      .prod (prod_w),
      .quot (quot_w)
   );

   int_alu_compare #(.DATA_W(DATA_W)) u_cmp (
      .a   (op_a),
      .b   (op_b),
      .rel (rel_w)
   );

   int_alu_shifter #(.DATA_W(DATA_W), .SHIFT_STAGED(SHIFT_STAGED)) u_shift (
      .data     (op_a),
      .amt      (op_b[AMT_W-1:0]),
      .go_right (fn == FN_SHR),
      .shifted  (shift_w)
   );

   function automatic logic [DATA_W-1:0] as_word(input logic flag);
      return {{(DATA_W-1){1'b0}}, flag};
   endfunction

   always_comb begin
      unique case (fn)
         FN_ADD:  result = sum_w;
         FN_SUB:  result = diff_w;
         FN_MUL:  result = prod_w;
         FN_DIV:  result = quot_w;
         FN_AND:  result = op_a & op_b;
         FN_OR:   result = op_a | op_b;
         FN_XOR:  result = op_a ^ op_b;
         FN_EQ:   result = as_word(rel_w.eq);
         FN_NE:   result = as_word(rel_w.ne);
         FN_LT:   result = as_word(rel_w.lt);
         FN_LE:   result = as_word(rel_w.le);
         FN_GT:   result = as_word(rel_w.gt);
         FN_GE:   result = as_word(rel_w.ge);
         FN_SHL,
         FN_SHR:  result = shift_w;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/int_alu_core_checker.sv
module int_alu_core_checker #(
   parameter int DATA_W = 32
) (
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [3:0]        func,
   input logic [DATA_W-1:0] result
);
   localparam int AMT_W = $clog2(DATA_W);
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   always_comb begin
      if (!$isunknown({op_a, op_b, func, result})) begin
         // R2: removing op_b from an add result gives op_a back
         if (func == 4'd0)
            p_add_undo_r2: assert (result - op_b == op_a);
         // R5: zero divisor
         if (func == 4'd3 && op_b == '0)
            p_div_zero_r5: assert (result == '1);
         // R6: overflowing quotient
         if (func == 4'd3 && op_a == MOST_NEG && op_b == '1)
            p_div_ovf_r6: assert (result == MOST_NEG);
         // R7: xor with all ones is the complement
         if (func == 4'd6 && op_b == '1)
            p_xor_complement_r7: assert (result == ~op_a);
         // R8: comparison results are exactly 0 or 1
         if (func >= 4'd7 && func <= 4'd12)
            p_bool_word_r8: assert (result[DATA_W-1:1] == '0);
         if (func == 4'd7)
            p_eq_match_r8: assert (result[0] == (op_a == op_b));
         if (func == 4'd9)
            p_lt_signed_r8: assert (result[0] == ($signed(op_a) < $signed(op_b)));
         // R9: only the low shift bits count
         if (func == 4'd13)
            p_shl_low_bits_r9: assert (result == (op_a << op_b[AMT_W-1:0]));
         // R10: logical right shift clears the top bit
         if (func == 4'd14 && op_b[AMT_W-1:0] != '0)
            p_shr_zero_fill_r10: assert (result[DATA_W-1] == 1'b0);
         // R11: unused code
         if (func == 4'd15)
            p_unused_code_r11: assert (result == '0);
      end
   end

endmodule

bind int_alu_core int_alu_core_checker #(.DATA_W(DATA_W)) u_chk (
   .op_a   (op_a),
   .op_b   (op_b),
   .func   (func),
   .result (result)
);

// File: tb/int_alu_core_test.sv
module int_alu_core_test;
   localparam int W = 32;
   localparam logic [W-1:0] MINV = 32'h8000_0000;
   localparam logic [W-1:0] MAXV = 32'h7FFF_FFFF;
   localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [3:0]   func = 4'd0;
   logic [W-1:0] result;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   int_alu_core #(.DATA_W(W), .SHIFT_STAGED(1'b1)) uut (
      .op_a   (op_a),
      .op_b   (op_b),
      .func   (func),
      .result (result)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic [3:0] f);
      logic signed [W-1:0] sa;
      logic signed [W-1:0] sb;
      sa = a;
      sb = b;
      case (f)
         4'd0:  return a + b;
         4'd1:  return a - b;
         4'd2:  return a * b;
         4'd3: begin
            if (b == '0) return ONES;
            if (a == MINV && b == ONES) return MINV;
            return sa / sb;
         end
         4'd4:  return a & b;
         4'd5:  return a | b;
         4'd6:  return a ^ b;
         4'd7:  return (sa == sb) ? 32'd1 : 32'd0;
         4'd8:  return (sa != sb) ? 32'd1 : 32'd0;
         4'd9:  return (sa <  sb) ? 32'd1 : 32'd0;
         4'd10: return (sa <= sb) ? 32'd1 : 32'd0;
         4'd11: return (sa >  sb) ? 32'd1 : 32'd0;
         4'd12: return (sa >= sb) ? 32'd1 : 32'd0;
         4'd13: return a << b[4:0];
         4'd14: return a >> b[4:0];
         default: return '0;
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] exp);
      n_checks++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s: func=%0d a=%h b=%h actual=%h expected=%h",
                  req, func, op_a, op_b, result, exp);
      end
   endtask

   task automatic apply(input string req, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [3:0] f,
                        input logic [W-1:0] exp);
      @(negedge clk);
      op_a = a;
      op_b = b;
      func = f;
      #2;
      check(req, exp);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      #2;
      check("R1 zero inputs", 32'd0);
   endtask

   task automatic t_code_map();
      logic [W-1:0] pa [4] = '{32'd100, 32'hFFFF_FFF9, MINV, 32'h1234_5678};
      logic [W-1:0] pb [4] = '{32'd7, 32'd2, ONES, 32'hFFFF_0021};
      for (int p = 0; p < 4; p++)
         for (int f = 0; f < 16; f++)
            apply("R1 code map", pa[p], pb[p], 4'(f), model(pa[p], pb[p], 4'(f)));
   endtask

   task automatic t_add_sub();
      apply("R2 add wrap", MAXV, 32'd1, 4'd0, MINV);
      apply("R2 sub wrap", 32'd0, 32'd1, 4'd1, ONES);
      apply("R2 add imm -5", 32'd3, 32'hFFFF_FFFB, 4'd0, 32'hFFFF_FFFE);
   endtask

   task automatic t_mul();
      apply("R3 mul low half", 32'h0001_0001, 32'h0001_0001, 4'd2, 32'h0002_0001);
      apply("R3 mul negative", 32'hFFFF_FFFD, 32'd4, 4'd2, 32'hFFFF_FFF4);
   endtask

   task automatic t_div();
      apply("R4 7/-2", 32'd7, 32'hFFFF_FFFE, 4'd3, 32'hFFFF_FFFD);
      apply("R4 -7/2", 32'hFFFF_FFF9, 32'd2, 4'd3, 32'hFFFF_FFFD);
      apply("R4 -7/-2", 32'hFFFF_FFF9, 32'hFFFF_FFFE, 4'd3, 32'd3);
      apply("R4 min/1", MINV, 32'd1, 4'd3, MINV);
      apply("R5 div by zero", 32'd42, 32'd0, 4'd3, ONES);
      apply("R5 neg div by zero", MINV, 32'd0, 4'd3, ONES);
      apply("R6 min/-1", MINV, ONES, 4'd3, MINV);
   endtask

   task automatic t_logic();
      apply("R7 and", 32'hF0F0_1234, 32'hFFFF_FFF0, 4'd4, 32'hF0F0_1230);
      apply("R7 or", 32'h0000_00F0, 32'h0F00_000F, 4'd5, 32'h0F00_00FF);
      apply("R7 complement", 32'h1234_5678, ONES, 4'd6, 32'hEDCB_A987);
   endtask

   task automatic t_compare();
      apply("R8 lt min<max", MINV, MAXV, 4'd9, 32'd1);
      apply("R8 gt -1>0", ONES, 32'd0, 4'd11, 32'd0);
      apply("R8 le equal", 32'd5, 32'd5, 4'd10, 32'd1);
      apply("R8 ge max>=min", MAXV, MINV, 4'd12, 32'd1);
      apply("R8 ne equal", ONES, ONES, 4'd8, 32'd0);
      apply("R8 eq differ", 32'd1, 32'd2, 4'd7, 32'd0);
   endtask

   task automatic t_shift();
      apply("R9 shl by 32 keeps", 32'hDEAD_BEEF, 32'd32, 4'd13, 32'hDEAD_BEEF);
      apply("R9 shl high bits ignored", 32'd1, 32'hFFFF_FFE5, 4'd13, 32'd32);
      apply("R9 shl 31", 32'd3, 32'd31, 4'd13, MINV);
      apply("R10 shr negative", ONES, 32'd4, 4'd14, 32'h0FFF_FFFF);
      apply("R10 shr 31", MINV, 32'd31, 4'd14, 32'd1);
      apply("R10 shr by 0", MINV, 32'd64, 4'd14, MINV);
   endtask

   task automatic t_unused();
      apply("R11 code 15", ONES, ONES, 4'd15, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset_state();
      t_code_map();
      t_add_sub();
      t_mul();
      t_div();
      t_logic();
      t_compare();
      t_shift();
      t_unused();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule